// File: doc/BRIEF.md
# UART Enable and Initialization Sequencer

This block holds the 8-bit control word of a simple UART and turns it into the run and stop signals that the transmit and receive engines obey. A host writes the word through a one-cycle write port and reads it back on a parallel output. Two enable bits start and stop the engines. Stopping is graceful: a frame already on the line is finished before the engine is released. Two initialization bits act as one-shot commands. They clear the engines' status flags, and they stop or abort whatever the engine is doing. Each initialization bit clears itself on the next clock.

The transmit side is run by a four-state machine: `TX_OFF`, `TX_WAIT_LOAD`, `TX_RUN` and `TX_DRAIN`. The transitions are as follows:
- Enable with a loaded buffer moves `TX_OFF` to `TX_RUN`.
- Enable without a load moves `TX_OFF` to `TX_WAIT_LOAD`.
- A detected reload moves `TX_WAIT_LOAD` to `TX_RUN`.
- Disable while busy moves `TX_RUN` to `TX_DRAIN`.
- Disable while idle moves `TX_RUN` to `TX_OFF`.
- Engine idle moves `TX_DRAIN` to `TX_OFF`.
- A transmit initialization moves any state to `TX_OFF`.

The receive side has four states: `RX_OFF`, `RX_LISTEN`, `RX_FINISH` and `RX_ABORT`. The transitions are as follows:
- Enable moves `RX_OFF` to `RX_LISTEN`.
- Disable while busy moves `RX_LISTEN` to `RX_FINISH`.
- Disable while idle moves `RX_LISTEN` to `RX_OFF`.
- Receiver idle moves `RX_FINISH` to `RX_OFF`.
- A receive initialization while the receiver is busy moves any state to `RX_ABORT`. While it is idle, the same command moves any state to `RX_OFF`.
- An abort acknowledge moves `RX_ABORT` to `RX_OFF`.

A separate edge detector raises the transmit interrupt. Depending on a select bit, it fires on the buffer-empty flag or on the transmit-complete flag. Two further bits choose whether the handshake pins work as modem-control pins or as general-purpose I/O. The top bit (multi-drop addressing) is only stored.

Top module: `uart_ctl_seq`

## Requirements
- R1: The control word resets to 0x00. A write stores `wr_data` and `ctl_rd` returns it on the next cycle. The field positions are bit0 transmit enable, bit1 receive enable, bit2 transmit init, bit3 receive init, bit4 interrupt select, bit5 clear-to-send pin select, bit6 request-to-send pin select and bit7 address mode.
- R2: `tx_go` is asserted only while transmit enable is 1 and the transmit buffer has been reloaded since reset or since the last transmit init. A reload is a 1-to-0 transition of `tx_buf_empty`.
- R3: Clearing transmit enable while `tx_busy` is 1 keeps `tx_go` high until `tx_busy` falls. It then drops.
- R4: `rx_go` follows receive enable. Clearing receive enable while `rx_busy` is 1 keeps `rx_go` high until `rx_busy` falls.
- R5: Writing bit2 = 1 clears transmit enable regardless of bit0, drops `tx_go`, and discards the buffer-loaded state. After that, sending needs both a new enable and a reload.
- R6: Writing bit3 = 1 clears receive enable. If `rx_busy` is 1 at that point, `rx_go` drops and `rx_abort` stays high until `rx_abort_ack`. If the receiver is idle, no abort is raised.
- R7: Each init bit reads 1, and drives its `tx_init`/`rx_init` pulse, for exactly the one cycle after the write, then clears itself.
- R8: With bit4 = 0 the transmit interrupt fires on a 0-to-1 transition of `tx_buf_empty`. With bit4 = 1 it fires on a 0-to-1 transition of `tx_cmpl`. The flag that is not selected is ignored.
- R9: `tx_irq` is a one-cycle pulse, registered one clock after the edge it reports, and it is never raised while transmit enable is 0.
- R10: `cts_sel` equals bit5 and `rts_sel` equals bit6. A value of 1 selects the handshake function and 0 selects general-purpose use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe for the control word |
| wr_data | input | 8 | Control word to write |
| ctl_rd | output | 8 | Control word readback |
| tx_busy | input | 1 | Transmit engine is shifting a frame |
| tx_cmpl | input | 1 | Transmit-complete flag from the engine |
| tx_buf_empty | input | 1 | Transmit buffer holds no data |
| rx_busy | input | 1 | Receive engine is inside a frame |
| rx_abort_ack | input | 1 | Receive engine has finished aborting |
| tx_go | output | 1 | Run enable to the transmit engine |
| rx_go | output | 1 | Run enable to the receive engine |
| tx_init | output | 1 | One-cycle transmit status clear and stop |
| rx_init | output | 1 | One-cycle receive status clear |
| rx_abort | output | 1 | Abort request to the receive engine |
| tx_irq | output | 1 | Transmit interrupt pulse |
| cts_sel | output | 1 | Clear-to-send pin function select |
| rts_sel | output | 1 | Request-to-send pin function select |

## Verification
The bench disables each engine in the middle of a frame. A design that cut the frame short would drop `tx_go` or `rx_go` while busy is still high. It also re-enables the transmitter after an init without first reloading the buffer; a design that forgot to discard the loaded state would restart sending. A write that sets transmit init and transmit enable together must leave the enable cleared. Random sequences of flag edges under both interrupt selections find a design that watches the wrong flag, holds the pulse longer than one cycle, or fires while disabled. A receive init while busy must hold the abort until the acknowledge arrives, and the same init while idle must raise no abort at all.

// File: rtl/uart_ctl_pkg.sv
package uart_ctl_pkg;

    localparam int CTL_W      = 8;
    localparam int B_TX_EN    = 0;
    localparam int B_RX_EN    = 1;
    localparam int B_TX_INIT  = 2;
    localparam int B_RX_INIT  = 3;
    localparam int B_IRQ_SEL  = 4;
    localparam int B_CTS_SEL  = 5;
    localparam int B_RTS_SEL  = 6;
    localparam int B_ADDR_MD  = 7;

    typedef enum logic [1:0] {
        TX_OFF       = 2'd0,
        TX_WAIT_LOAD = 2'd1,
        TX_RUN       = 2'd2,
        TX_DRAIN     = 2'd3
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_OFF    = 2'd0,
        RX_LISTEN = 2'd1,
        RX_FINISH = 2'd2,
        RX_ABORT  = 2'd3
    } rx_state_t;

endpackage

// File: rtl/uart_ctl_word.sv
module uart_ctl_word
    import uart_ctl_pkg::*;
#(
    parameter int W = CTL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] ctl_q
);

    logic [W-1:0] next_word;

    always_comb begin
        next_word = ctl_q;
        next_word[B_TX_INIT] = 1'b0;
        next_word[B_RX_INIT] = 1'b0;
        if (wr_en) begin
            next_word = wr_data;
            if (wr_data[B_TX_INIT]) begin
                next_word[B_TX_EN] = 1'b0;
            end
            if (wr_data[B_RX_INIT]) begin
                next_word[B_RX_EN] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= next_word;
        end
    end

    // R7
    tx_init_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[B_TX_INIT] && !wr_en) |=> !ctl_q[B_TX_INIT]);

    // R7
    rx_init_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[B_RX_INIT] && !wr_en) |=> !ctl_q[B_RX_INIT]);

    // R6
    rx_init_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[B_RX_INIT] |-> !ctl_q[B_RX_EN]);

    // R5
    tx_init_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[B_TX_INIT] |-> !ctl_q[B_TX_EN]);

endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
    import uart_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic tx_init,
    input  logic tx_busy,
    input  logic tx_buf_empty,
    output logic tx_go
);

    tx_state_t state_q;
    tx_state_t state_d;
    logic      empty_prev_q;
    logic      loaded_q;
    logic      reload_seen;

    assign reload_seen = empty_prev_q && !tx_buf_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            empty_prev_q <= 1'b1;
            loaded_q     <= 1'b0;
        end else begin
            empty_prev_q <= tx_buf_empty;
            if (tx_init) begin
                loaded_q <= 1'b0;
            end else if (reload_seen) begin
                loaded_q <= 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        if (tx_init) begin
            state_d = TX_OFF;
        end else begin
            unique case (state_q)
                TX_OFF: begin
                    if (tx_en && loaded_q) begin
                        state_d = TX_RUN;
                    end else if (tx_en) begin
                        state_d = TX_WAIT_LOAD;
                    end
                end
                TX_WAIT_LOAD: begin
                    if (!tx_en) begin
                        state_d = TX_OFF;
                    end else if (loaded_q) begin
                        state_d = TX_RUN;
                    end
                end
                TX_RUN: begin
                    if (!tx_en && tx_busy) begin
                        state_d = TX_DRAIN;
                    end else if (!tx_en) begin
                        state_d = TX_OFF;
                    end
                end
                TX_DRAIN: begin
                    if (!tx_busy) begin
                        state_d = TX_OFF;
                    end
                end
                default: state_d = TX_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            TX_RUN, TX_DRAIN: tx_go = 1'b1;
            default:          tx_go = 1'b0;
        endcase
    end

    // R3
    tx_drain_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_go && tx_busy && !tx_init) |=> tx_go);

    // R2
    tx_start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_go) |-> $past(tx_en));

    // R5
    tx_init_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_init |=> !tx_go);

endmodule

// File: rtl/uart_rx_seq.sv
module uart_rx_seq
    import uart_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic rx_init,
    input  logic rx_busy,
    input  logic rx_abort_ack,
    output logic rx_go,
    output logic rx_abort
);

    rx_state_t state_q;
    rx_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (rx_init) begin
            state_d = rx_busy ? RX_ABORT : RX_OFF;
        end else begin
            unique case (state_q)
                RX_OFF: begin
                    if (rx_en) begin
                        state_d = RX_LISTEN;
                    end
                end
                RX_LISTEN: begin
                    if (!rx_en && rx_busy) begin
                        state_d = RX_FINISH;
                    end else if (!rx_en) begin
                        state_d = RX_OFF;
                    end
                end
                RX_FINISH: begin
                    if (!rx_busy) begin
                        state_d = RX_OFF;
                    end
                end
                RX_ABORT: begin
                    if (rx_abort_ack) begin
                        state_d = RX_OFF;
                    end
                end
                default: state_d = RX_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rx_go    = 1'b0;
        rx_abort = 1'b0;
        unique case (state_q)
            RX_LISTEN, RX_FINISH: rx_go = 1'b1;
            RX_ABORT:             rx_abort = 1'b1;
            default: begin
                rx_go    = 1'b0;
                rx_abort = 1'b0;
            end
        endcase
    end

    // R6
    rx_abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_abort && !rx_abort_ack) |=> rx_abort);

    // R6
    rx_abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_go && rx_abort));

    // R4
    rx_finish_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_go && rx_busy && !rx_init) |=> rx_go);

endmodule

// File: rtl/uart_tx_irq.sv
module uart_tx_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic irq_sel,
    input  logic tx_buf_empty,
    input  logic tx_cmpl,
    output logic tx_irq
);

    logic empty_prev_q;
    logic cmpl_prev_q;
    logic empty_rise;
    logic cmpl_rise;
    logic sel_rise;

    assign empty_rise = tx_buf_empty && !empty_prev_q;
    assign cmpl_rise  = tx_cmpl && !cmpl_prev_q;
    assign sel_rise   = irq_sel ? cmpl_rise : empty_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            empty_prev_q <= 1'b1;
            cmpl_prev_q  <= 1'b1;
            tx_irq       <= 1'b0;
        end else begin
            empty_prev_q <= tx_buf_empty;
            cmpl_prev_q  <= tx_cmpl;
            tx_irq       <= tx_en && sel_rise;
        end
    end

    // R9
    irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    // R9
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> $past(tx_en));

endmodule

// File: rtl/uart_ctl_seq.sv
module uart_ctl_seq
    import uart_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output logic [CTL_W-1:0] ctl_rd,
    input  logic             tx_busy,
    input  logic             tx_cmpl,
    input  logic             tx_buf_empty,
    input  logic             rx_busy,
    input  logic             rx_abort_ack,
    output logic             tx_go,
    output logic             rx_go,
    output logic             tx_init,
    output logic             rx_init,
    output logic             rx_abort,
    output logic             tx_irq,
    output logic             cts_sel,
    output logic             rts_sel
);

    logic [CTL_W-1:0] ctl_q;

    uart_ctl_word #(.W(CTL_W)) u_word (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctl_q   (ctl_q)
    );

    uart_tx_seq u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_en        (ctl_q[B_TX_EN]),
        .tx_init      (ctl_q[B_TX_INIT]),
        .tx_busy      (tx_busy),
        .tx_buf_empty (tx_buf_empty),
        .tx_go        (tx_go)
    );

    uart_rx_seq u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_en        (ctl_q[B_RX_EN]),
        .rx_init      (ctl_q[B_RX_INIT]),
        .rx_busy      (rx_busy),
        .rx_abort_ack (rx_abort_ack),
        .rx_go        (rx_go),
        .rx_abort     (rx_abort)
    );

    uart_tx_irq u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_en        (ctl_q[B_TX_EN]),
        .irq_sel      (ctl_q[B_IRQ_SEL]),
        .tx_buf_empty (tx_buf_empty),
        .tx_cmpl      (tx_cmpl),
        .tx_irq       (tx_irq)
    );

    assign ctl_rd  = ctl_q;
    assign tx_init = ctl_q[B_TX_INIT];
    assign rx_init = ctl_q[B_RX_INIT];
    assign cts_sel = ctl_q[B_CTS_SEL];
    assign rts_sel = ctl_q[B_RTS_SEL];

    // R1
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data[B_TX_INIT] == 1'b0) && (wr_data[B_RX_INIT] == 1'b0))
        |=> (ctl_rd == $past(wr_data)));

endmodule

// File: tb/uart_ctl_seq_test.sv
module uart_ctl_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] ctl_rd;
    logic       tx_busy = 1'b0;
    logic       tx_cmpl = 1'b0;
    logic       tx_buf_empty = 1'b1;
    logic       rx_busy = 1'b0;
    logic       rx_abort_ack = 1'b0;
    logic       tx_go, rx_go, tx_init, rx_init, rx_abort, tx_irq, cts_sel, rts_sel;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    uart_ctl_seq uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ctl_rd(ctl_rd),
        .tx_busy(tx_busy), .tx_cmpl(tx_cmpl), .tx_buf_empty(tx_buf_empty),
        .rx_busy(rx_busy), .rx_abort_ack(rx_abort_ack),
        .tx_go(tx_go), .rx_go(rx_go), .tx_init(tx_init), .rx_init(rx_init),
        .rx_abort(rx_abort), .tx_irq(tx_irq), .cts_sel(cts_sel), .rts_sel(rts_sel)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    function automatic logic exp_irq(input logic en, input logic sel, input logic emp,
                                     input logic pemp, input logic cm, input logic pcm);
        return en && (sel ? (cm && !pcm) : (emp && !pemp));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic pe, pc, exp;
        void'($urandom(32'h5eed_1234));
        tick(3);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 reset word", ctl_rd, 8'h00);
        chk("R2 reset tx_go", {7'b0, tx_go}, 8'h00);
        chk("R4 reset rx_go", {7'b0, rx_go}, 8'h00);
        chk("R9 reset irq", {7'b0, tx_irq}, 8'h00);

        // R1 / R10: random readback, init bits and enables kept 0
        for (int i = 0; i < 40; i++) begin
            logic [7:0] d;
            d = 8'($urandom()) & 8'hF0;
            write(d);
            chk("R1 readback", ctl_rd, d);
            chk("R10 pin selects", {6'b0, rts_sel, cts_sel}, {6'b0, d[6], d[5]});
        end
        write(8'h00);
        tick(2);

        // R2: enable without reload does not start
        write(8'h01);
        tick(3);
        chk("R2 no reload no go", {7'b0, tx_go}, 8'h00);
        tx_buf_empty = 1'b0;
        tick(3);
        chk("R2 reload starts", {7'b0, tx_go}, 8'h01);

        // R3: disable mid-frame drains
        tx_busy = 1'b1;
        tick();
        write(8'h00);
        tick(4);
        chk("R3 drain holds", {7'b0, tx_go}, 8'h01);
        tx_busy = 1'b0;
        tick(2);
        chk("R3 drain ends", {7'b0, tx_go}, 8'h00);

        // R2: re-enable keeps loaded state
        write(8'h01);
        tick(3);
        chk("R2 re-enable", {7'b0, tx_go}, 8'h01);

        // R5 / R7: transmit init with enable bit also written
        write(8'h05);
        chk("R7 tx init reads 1", {5'b0, ctl_rd[2], tx_init, ctl_rd[0]}, 8'h06);
        tick();
        chk("R7 tx init clears", {6'b0, ctl_rd[2], tx_init}, 8'h00);
        chk("R5 tx_go dropped", {7'b0, tx_go}, 8'h00);
        write(8'h01);
        tick(4);
        chk("R5 no go without reload", {7'b0, tx_go}, 8'h00);
        tx_buf_empty = 1'b1;
        tick();
        tx_buf_empty = 1'b0;
        tick(3);
        chk("R5 go after reload", {7'b0, tx_go}, 8'h01);

        // R8 / R9 directed
        tx_buf_empty = 1'b1;
        tick();
        chk("R8 empty edge irq", {7'b0, tx_irq}, 8'h01);
        tick();
        chk("R9 one cycle", {7'b0, tx_irq}, 8'h00);
        write(8'h11);
        tx_cmpl = 1'b1;
        tick();
        chk("R8 cmpl edge irq", {7'b0, tx_irq}, 8'h01);
        tx_buf_empty = 1'b0;
        tick();
        tx_buf_empty = 1'b1;
        tick();
        chk("R8 unselected ignored", {7'b0, tx_irq}, 8'h00);
        write(8'h10);
        tx_cmpl = 1'b0;
        tick();
        tx_cmpl = 1'b1;
        tick();
        chk("R9 suppressed when disabled", {7'b0, tx_irq}, 8'h00);

        // R8 / R9 random flag edges
        for (int s = 0; s < 2; s++) begin
            write(s == 0 ? 8'h01 : 8'h11);
            tick();
            pe = tx_buf_empty;
            pc = tx_cmpl;
            for (int i = 0; i < 200; i++) begin
                tx_buf_empty = 1'($urandom());
                tx_cmpl = 1'($urandom());
                exp = exp_irq(1'b1, 1'(s), tx_buf_empty, pe, tx_cmpl, pc);
                tick();
                chk("R8 random irq", {7'b0, tx_irq}, {7'b0, exp});
                pe = tx_buf_empty;
                pc = tx_cmpl;
            end
        end
        write(8'h00);
        tx_busy = 1'b0;
        tick(2);

        // R4: receive enable and finish
        write(8'h02);
        tick(2);
        chk("R4 rx enabled", {7'b0, rx_go}, 8'h01);
        rx_busy = 1'b1;
        tick();
        write(8'h00);
        tick(4);
        chk("R4 rx finish holds", {7'b0, rx_go}, 8'h01);
        rx_busy = 1'b0;
        tick(2);
        chk("R4 rx finish ends", {7'b0, rx_go}, 8'h00);

        // R6 / R7: receive init while busy aborts
        write(8'h02);
        tick(2);
        rx_busy = 1'b1;
        tick();
        write(8'h0A);
        chk("R7 rx init reads 1", {5'b0, ctl_rd[3], rx_init, ctl_rd[1]}, 8'h06);
        tick();
        chk("R7 rx init clears", {6'b0, ctl_rd[3], rx_init}, 8'h00);
        chk("R6 abort raised", {6'b0, rx_abort, rx_go}, 8'h02);
        tick(5);
        chk("R6 abort held", {7'b0, rx_abort}, 8'h01);
        rx_abort_ack = 1'b1;
        rx_busy = 1'b0;
        tick();
        rx_abort_ack = 1'b0;
        chk("R6 abort released", {7'b0, rx_abort}, 8'h00);

        // R6: receive init while idle gives no abort
        write(8'h02);
        tick(2);
        write(8'h08);
        tick(2);
        chk("R6 idle init no abort", {6'b0, rx_abort, rx_go}, 8'h00);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule